// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small multicycle processor in which a single 16-bit accumulator stands in for a register file. Every instruction names exactly one memory word. The accumulator is always the other operand and always receives the result. Store is the exception: it writes the accumulator out to the named word.

Each instruction runs through a fixed fetch sequence built on a program counter, a memory address register, a memory data register and an instruction register. A decode step follows. An execute step then makes one access to memory through the address and data registers. The core talks to a word-addressed synchronous memory over one port, and it signals through a halted output once it has stopped.

Top module: `acc_cpu`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high, the core sets `mem_addr` to 0 and clears `mem_we` and `halted`. It also clears the program counter and the accumulator, so a store executed first after reset writes 0.
- R2: An instruction word carries its opcode in bits [15:13]: load=0, store=1, add=2, subtract=3, multiply=4, stop=5. It carries the operand address in bits [9:0]. Bits [12:10] have no effect on execution.
- R3: Load copies memory word x into the accumulator, and store writes the accumulator into memory word x.
- R4: Add sets the accumulator to the accumulator plus M[x], modulo 2^16.
- R5: Subtract sets the accumulator to the accumulator minus M[x], modulo 2^16.
- R6: Multiply keeps the low 16 bits of the accumulator times M[x].
- R7: Instructions are fetched from consecutive word addresses starting at 0, and the program counter advances by 1 for each one.
- R8: A store occupies 6 clock cycles and load, add, subtract and multiply occupy 8 each. For a stop, `halted` rises at the end of its fifth cycle.
- R9: Stop and the undefined opcodes 6 and 7 raise `halted`, which then stays high until reset. While halted, `mem_we` stays 0, `mem_addr` holds its value and no later instruction executes.
- R10: Each store drives `mem_we` high for exactly one cycle, with `mem_addr` and `mem_wdata` valid in that cycle. Read data is taken one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 10 | Registered word address to memory |
| mem_wdata | output | 16 | Registered write data to memory |
| mem_rdata | input | 16 | Read data, valid one cycle after address |
| mem_we | output | 1 | Registered write enable, one cycle per store |
| halted | output | 1 | High once stop or an undefined opcode is decoded |

## Verification
The bound checker watches the port protocol on every cycle. It checks the reset values, that the write enable never lasts more than one cycle, and that once halted the core stays halted with the address frozen and no write. The arithmetic results, the wrap-around cases, the ignored reserved bits, the skipped store after an undefined opcode and the exact cycle count of each instruction class can only be seen through the bench's programs. The bench checks these by reading memory after the core halts and by counting cycles up to halt.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int OPW = 3;

  typedef enum logic [OPW-1:0] {
    OP_LD   = 3'd0,
    OP_ST   = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_MUL  = 3'd4,
    OP_STOP = 3'd5,
    OP_U6   = 3'd6,
    OP_U7   = 3'd7
  } op_e;

  typedef enum logic [3:0] {
    PH_FADR,
    PH_FWAIT,
    PH_FMDR,
    PH_FIR,
    PH_DEC,
    PH_EWAIT,
    PH_EMDR,
    PH_EOP,
    PH_EWR,
    PH_HALT
  } phase_e;

  typedef struct packed {
    logic mar_pc;
    logic mar_ir;
    logic mdr_mem;
    logic mdr_acc;
    logic ir_ld;
    logic pc_inc;
    logic acc_ld;
    logic we_set;
    logic halt_set;
  } ctl_s;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_cpu_pkg::*;
#(
  parameter int DW = 16
) (
  input  op_e           op,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] opnd,
  output logic [DW-1:0] res
);

  logic [DW-1:0] sum_w;
  logic [DW-1:0] dif_w;
  logic [DW-1:0] mul_w;

  always_comb begin
    sum_w = acc + opnd;
    dif_w = acc - opnd;
    mul_w = acc * opnd;
  end

  always_comb begin
    unique case (op)
      OP_ADD:  res = sum_w;
      OP_SUB:  res = dif_w;
      OP_MUL:  res = mul_w;
      default: res = opnd;
    endcase
  end

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_cpu_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  op_e  op,
  output ctl_s ctl
);

  phase_e ph_q, ph_d;
  logic   stop_op;

  always_comb begin
    stop_op = (op == OP_STOP) || (op == OP_U6) || (op == OP_U7);
  end

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_FADR:  ph_d = PH_FWAIT;
      PH_FWAIT: ph_d = PH_FMDR;
      PH_FMDR:  ph_d = PH_FIR;
      PH_FIR:   ph_d = PH_DEC;
      PH_DEC: begin
        if (stop_op)         ph_d = PH_HALT;
        else if (op == OP_ST) ph_d = PH_EWR;
        else                 ph_d = PH_EWAIT;
      end
      PH_EWAIT: ph_d = PH_EMDR;
      PH_EMDR:  ph_d = PH_EOP;
      PH_EOP:   ph_d = PH_FADR;
      PH_EWR:   ph_d = PH_FADR;
      PH_HALT:  ph_d = PH_HALT;
      default:  ph_d = PH_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) ph_q <= PH_FADR;
    else     ph_q <= ph_d;
  end

  always_comb begin
    ctl          = '0;
    ctl.mar_pc   = (ph_q == PH_FADR);
    ctl.mdr_mem  = (ph_q == PH_FMDR) || (ph_q == PH_EMDR);
    ctl.ir_ld    = (ph_q == PH_FIR);
    ctl.pc_inc   = (ph_q == PH_FIR);
    ctl.mar_ir   = (ph_q == PH_DEC) && !stop_op;
    ctl.mdr_acc  = (ph_q == PH_DEC) && (op == OP_ST);
    ctl.we_set   = (ph_q == PH_DEC) && (op == OP_ST);
    ctl.acc_ld   = (ph_q == PH_EOP);
    ctl.halt_set = (ph_q == PH_DEC) && stop_op;
  end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we,
  output logic          halted
);

  localparam int IRW    = OPW + AW;
  localparam int OP_LSB = DW - OPW;

  logic [AW-1:0]  pc_q;
  logic [AW-1:0]  mar_q;
  logic [DW-1:0]  mdr_q;
  logic [IRW-1:0] ir_q;
  logic [DW-1:0]  acc_q;
  logic           we_q;
  logic           halt_q;
  ctl_s           ctl;
  op_e            ir_op;
  logic [DW-1:0]  alu_res;

  assign ir_op = op_e'(ir_q[IRW-1 -: OPW]);

  acc_ctrl u_ctrl (
    .clk (clk),
    .rst (rst),
    .op  (ir_op),
    .ctl (ctl)
  );

  acc_alu #(.DW(DW)) u_alu (
    .op   (ir_op),
    .acc  (acc_q),
    .opnd (mdr_q),
    .res  (alu_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      mar_q  <= '0;
      mdr_q  <= '0;
      ir_q   <= '0;
      acc_q  <= '0;
      we_q   <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      if (ctl.mar_pc)       mar_q <= pc_q;
      else if (ctl.mar_ir)  mar_q <= ir_q[AW-1:0];
      if (ctl.mdr_mem)      mdr_q <= mem_rdata;
      else if (ctl.mdr_acc) mdr_q <= acc_q;
      if (ctl.ir_ld)        ir_q  <= {mdr_q[DW-1 -: OPW], mdr_q[AW-1:0]};
      if (ctl.pc_inc)       pc_q  <= pc_q + 1'b1;
      if (ctl.acc_ld)       acc_q <= alu_res;
      we_q   <= ctl.we_set;
      halt_q <= halt_q | ctl.halt_set;
    end
  end

  assign mem_addr  = mar_q;
  assign mem_wdata = mdr_q;
  assign mem_we    = we_q;
  assign halted    = halt_q;

  // reserved field bits lie between address and opcode and are dropped
  if (OP_LSB < AW) begin : g_bad_layout
    initial $error("opcode field overlaps address field");
  end

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic          halted
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (mem_addr == '0 && !mem_we && !halted));

  // R10
  we_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R9
  halt_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> ($stable(mem_addr) && !mem_we));

  // R9
  halt_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(halted) |-> !mem_we);

endmodule

bind acc_cpu acc_cpu_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mem_addr (mem_addr),
  .mem_we   (mem_we),
  .halted   (halted)
);

// File: tb/sim_acc_cpu.sv
`timescale 1ns/100ps
module sim_acc_cpu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        mem_we;
  logic        halted;
  logic [15:0] mem [0:1023];
  int          n_chk = 0;
  int          n_bad = 0;
  int          we_cnt = 0;

  always #2.5 clk = ~clk;

  acc_cpu u0 (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_we    (mem_we),
    .halted    (halted)
  );

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      we_cnt <= we_cnt + 1;
    end
    mem_rdata <= mem[mem_addr];
  end

  function automatic logic [15:0] enc(input int op, input int adr);
    return 16'((op << 13) | (adr & 10'h3FF));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0;
  endtask

  task automatic start_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  // releases reset and counts cycles until halted rises
  task automatic run(output int cyc);
    cyc = 0;
    @(negedge clk);
    we_cnt = 0;
    rst = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk);
      cyc++;
      #1;
      if (halted) break;
    end
  endtask

  task automatic t_reset();
    start_reset();
    chk("R1 mem_addr in reset", 32'(mem_addr), 0);
    chk("R1 mem_we in reset", 32'(mem_we), 0);
    chk("R1 halted in reset", 32'(halted), 0);
  endtask

  task automatic t_arith();
    int cyc;
    start_reset();
    clear_mem();
    mem[100] = 16'd7; mem[101] = 16'd5;
    mem[0] = enc(0,100); mem[1] = enc(2,101); mem[2] = enc(1,200);
    mem[3] = enc(0,100); mem[4] = enc(3,101); mem[5] = enc(4,200);
    mem[6] = enc(1,201); mem[7] = enc(5,0);
    run(cyc);
    chk("R3 R4 R7 load add store", 32'(mem[200]), 32'd12);
    chk("R5 R6 sub then mul", 32'(mem[201]), 32'd24);
    // 4 eight-cycle ops + 2 stores (6) + mul (8) + stop (5)
    chk("R8 cycle count", 32'(cyc), 32'(8*5 + 6*2 + 5));
    chk("R10 write pulses", 32'(we_cnt), 32'd2);
    chk("R9 halted", 32'(halted), 1);
  endtask

  task automatic t_wrap();
    int cyc;
    start_reset();
    clear_mem();
    mem[100] = 16'hFFF0; mem[101] = 16'h0020;
    mem[0] = enc(0,100); mem[1] = enc(2,101); mem[2] = enc(1,300);
    mem[3] = enc(0,101); mem[4] = enc(3,100); mem[5] = enc(1,301);
    mem[6] = enc(0,100); mem[7] = enc(4,100); mem[8] = enc(1,302);
    mem[9] = enc(5,0);
    run(cyc);
    chk("R4 add wraps", 32'(mem[300]), 32'(16'(16'hFFF0 + 16'h0020)));
    chk("R5 sub wraps", 32'(mem[301]), 32'(16'(16'h0020 - 16'hFFF0)));
    chk("R6 mul low half", 32'(mem[302]), 32'h0100);
  endtask

  task automatic t_acc_clear();
    int cyc;
    start_reset();
    mem[400] = 16'hAAAA;
    mem[0] = enc(1,400); mem[1] = enc(5,0);
    run(cyc);
    chk("R1 accumulator cleared", 32'(mem[400]), 0);
    chk("R8 store plus stop cycles", 32'(cyc), 32'd11);
  endtask

  task automatic t_reserved();
    int cyc;
    start_reset();
    clear_mem();
    mem[100] = 16'h5A5A;
    mem[0] = enc(0,100) | 16'h1C00; mem[1] = enc(1,500) | 16'h0400;
    mem[2] = enc(5,0) | 16'h0800;
    run(cyc);
    chk("R2 reserved bits ignored", 32'(mem[500]), 32'h5A5A);
  endtask

  task automatic t_undef(input int code);
    int cyc;
    logic [9:0] a0;
    start_reset();
    clear_mem();
    mem[100] = 16'h0042; mem[600] = 16'h1234;
    mem[0] = enc(0,100); mem[1] = enc(code,600); mem[2] = enc(1,600);
    mem[3] = enc(5,0);
    run(cyc);
    chk("R9 undefined opcode halts", 32'(halted), 1);
    chk("R8 halt timing after load", 32'(cyc), 32'd13);
    a0 = mem_addr;
    repeat (20) @(posedge clk);
    #1;
    chk("R9 following store skipped", 32'(mem[600]), 32'h1234);
    chk("R9 address frozen", 32'(mem_addr), 32'(a0));
    chk("R9 halted held", 32'(halted), 1);
    chk("R10 no write while halted", 32'(we_cnt), 0);
  endtask

  task automatic t_seq();
    int cyc;
    start_reset();
    clear_mem();
    for (int i = 0; i < 10; i++) mem[i] = enc(1, 700 + i);
    mem[10] = enc(5,0);
    run(cyc);
    chk("R7 ten sequential stores", 32'(we_cnt), 32'd10);
    chk("R8 ten stores timing", 32'(cyc), 32'd65);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    clear_mem();
    t_reset();
    t_arith();
    t_reset();
    t_wrap();
    t_acc_clear();
    t_reserved();
    t_undef(6);
    t_undef(7);
    t_seq();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule